// File: doc/BRIEF.md
# Codec Power and Output Ramp Sequencer

This block holds the power-control state of an audio codec and sequences two timed events from it. A host writes bytes into three small registers through a simple write port. One register carries per-function standby bits: converter, mixer and headphone output stage. The output-stage bit drives a level counter that climbs or falls one step per clock. Each completed climb or fall posts its own sticky completion flag in a flag register.

Software drives a transition in a fixed order. It first clears the completion flag it expects, then flips the output-stage standby bit, then polls the flag register until hardware sets that flag. A second register holds a global standby bit and a sleep bit. Leaving global standby starts a settle timer, and a `ready` output rises only once that timer has expired and neither standby nor sleep is set. The ramp and settle lengths are parameters counted in clocks, so a short run can use small values.

Top module: `codec_pwr_seq`

## Requirements
- R1: After reset the power register at address 0 reads 0xFF and the global register at address 1 reads 0x03. Both flags are clear, `out_level` is 0, `ready` is 0, and all three converter/mixer standby outputs are 1.
- R2: A write that clears bit 6 of address 0 makes `out_level` rise by one per clock, starting on the clock after the write edge, until it reaches RAMP_LEN. The ramp-up flag (bit 3 of address 2) then sets RAMP_LEN+1 clocks after the write edge.
- R3: A write that sets bit 6 of address 0 while `out_level` is RAMP_LEN makes `out_level` fall by one per clock to 0. The ramp-down flag (bit 2 of address 2) then sets RAMP_LEN+1 clocks after the write edge.
- R4: Both completion flags are sticky until software clears them. A write to address 2 clears each flag whose bit is written 0 and leaves alone each flag whose bit is written 1. A hardware completion in the same cycle wins over the clear.
- R5: If bit 6 changes while a ramp is running, the level turns around from where it stands. Only the flag of the direction that finally reaches its end point is set.
- R6: `rd_data` shows the live contents of the register at `rd_addr` one clock after it is presented. The flag register reads with bit 3 = ramp-up flag, bit 2 = ramp-down flag and all other bits 0.
- R7: `dac_standby`, `mixer_standby` and `adc_standby` follow bits 7, 5 and 4 of address 0 from the write edge on, and those bits leave the ramp untouched.
- R8: In address 1, bit 1 is global standby and bit 0 is sleep. After a write that clears both, `ready` rises SETTLE_LEN+1 clocks after the write edge.
- R9: `ready` falls one clock after sleep or global standby is set. Sleep does not restart the settle timer, so `ready` returns one clock after sleep clears. Re-entering global standby restarts the full settle delay.
- R10: Writes to any address other than 0, 1 or 2 change nothing, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Registered read data |
| dac_standby | output | 1 | DAC standby control (bit 7 of address 0) |
| adc_standby | output | 1 | ADC standby control (bit 4 of address 0) |
| mixer_standby | output | 1 | Mixer standby control (bit 5 of address 0) |
| out_level | output | LVL_W = clog2(RAMP_LEN+1) | Current output-stage ramp level |
| ramp_up_flag | output | 1 | Sticky ramp-up completion flag |
| ramp_down_flag | output | 1 | Sticky ramp-down completion flag |
| ready | output | 1 | Settled and neither standby nor sleep set |

## Verification
The assertions take for granted that writes are single-cycle strobes with a stable address. They also assume RAMP_LEN and SETTLE_LEN are at least 2, so a ramp always spans several clocks and a step check can tell a rise from a fall. The stimulus keeps to this. It issues one write per task call, each with `wr_en` high for exactly one edge, and it uses short parameter values. It reverses the output-stage bit only at a known level partway through a ramp, so the turnaround point and the single resulting flag can be predicted.

// File: rtl/codec_pwr_pkg.sv
`timescale 1ns/1ps
package codec_pwr_pkg;
  // register indices
  localparam int REG_PWR_A = 0;
  localparam int REG_PWR_B = 1;
  localparam int REG_FLAGS = 2;
  // bit positions in the power register
  localparam int BIT_DAC_SB   = 7;
  localparam int BIT_STAGE_SB = 6;
  localparam int BIT_MIX_SB   = 5;
  localparam int BIT_ADC_SB   = 4;
  // bit positions in the global register
  localparam int BIT_GSB   = 1;
  localparam int BIT_SLEEP = 0;
  // bit positions in the flag register
  localparam int BIT_UP_DONE   = 3;
  localparam int BIT_DOWN_DONE = 2;
  // reset values
  localparam logic [7:0] PWR_A_RST = 8'hFF;
  localparam logic [7:0] PWR_B_RST = 8'h03;
endpackage

// File: rtl/cpwr_regs.sv
`timescale 1ns/1ps
module cpwr_regs
  import codec_pwr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              set_up,
  input  logic              set_down,
  output logic [7:0]        rd_data,
  output logic              stage_sb,
  output logic              dac_sb,
  output logic              adc_sb,
  output logic              mix_sb,
  output logic              gsb,
  output logic              sleep,
  output logic              flag_up,
  output logic              flag_down
);
  localparam logic [ADDR_W-1:0] A_PWR_A = ADDR_W'(REG_PWR_A);
  localparam logic [ADDR_W-1:0] A_PWR_B = ADDR_W'(REG_PWR_B);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(REG_FLAGS);

  logic [7:0] pwr_a, pwr_b, flags_byte;
  logic [1:0] flg, set_vec;
  logic       wr_a, wr_b, wr_f;

  assign wr_a = wr_en && (wr_addr == A_PWR_A);
  assign wr_b = wr_en && (wr_addr == A_PWR_B);
  assign wr_f = wr_en && (wr_addr == A_FLAGS);
  assign set_vec = {set_up, set_down};

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_a <= PWR_A_RST;
      pwr_b <= PWR_B_RST;
    end else begin
      if (wr_a) pwr_a <= wr_data;
      if (wr_b) pwr_b <= wr_data;
    end
  end

  // index 0 = down flag, index 1 = up flag; bit position BIT_DOWN_DONE + i
  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                  flg[i] <= 1'b0;
      else if (set_vec[i])                      flg[i] <= 1'b1;
      else if (wr_f && !wr_data[BIT_DOWN_DONE+i]) flg[i] <= 1'b0;
    end

    // R4
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flg[i]) |-> $past(wr_en && wr_addr == A_FLAGS));
    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flg[i]) |-> $past(set_vec[i]));
  end

  always_comb begin
    flags_byte = '0;
    flags_byte[BIT_UP_DONE]   = flg[1];
    flags_byte[BIT_DOWN_DONE] = flg[0];
  end

  always_ff @(posedge clk) begin
    if (rst)                     rd_data <= '0;
    else if (rd_addr == A_PWR_A) rd_data <= pwr_a;
    else if (rd_addr == A_PWR_B) rd_data <= pwr_b;
    else if (rd_addr == A_FLAGS) rd_data <= flags_byte;
    else                         rd_data <= '0;
  end

  assign stage_sb  = pwr_a[BIT_STAGE_SB];
  assign dac_sb    = pwr_a[BIT_DAC_SB];
  assign adc_sb    = pwr_a[BIT_ADC_SB];
  assign mix_sb    = pwr_a[BIT_MIX_SB];
  assign gsb       = pwr_b[BIT_GSB];
  assign sleep     = pwr_b[BIT_SLEEP];
  assign flag_up   = flg[1];
  assign flag_down = flg[0];

  // R10
  pwr_a_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_a) |-> $past(wr_en && wr_addr == A_PWR_A));
endmodule

// File: rtl/cpwr_ramp.sv
`timescale 1ns/1ps
module cpwr_ramp #(
  parameter int RAMP_LEN = 1024,
  localparam int LVL_W = $clog2(RAMP_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stage_sb,
  output logic [LVL_W-1:0] level,
  output logic             up_done,
  output logic             down_done
);
  localparam logic [LVL_W-1:0] TOP  = LVL_W'(RAMP_LEN);
  localparam logic [LVL_W-1:0] ZERO = '0;
  localparam logic [LVL_W-1:0] ONE  = LVL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      level     <= ZERO;
      up_done   <= 1'b0;
      down_done <= 1'b0;
    end else begin
      up_done   <= 1'b0;
      down_done <= 1'b0;
      if (!stage_sb && level != TOP) begin
        level <= level + ONE;
        if (level == TOP - ONE) up_done <= 1'b1;
      end else if (stage_sb && level != ZERO) begin
        level <= level - ONE;
        if (level == ONE) down_done <= 1'b1;
      end
    end
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> ((level == $past(level) + ONE) || ($past(level) == level + ONE)));
  // R2
  up_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    up_done |-> (level == TOP));
  // R3
  down_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    down_done |-> (level == ZERO));
  // R5
  up_dir_chk: assert property (@(posedge clk) disable iff (rst)
    up_done |-> $past(!stage_sb));
endmodule

// File: rtl/cpwr_settle.sv
`timescale 1ns/1ps
module cpwr_settle #(
  parameter int SETTLE_LEN = 2688000,
  localparam int CNT_W = $clog2(SETTLE_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic gsb,
  input  logic sleep,
  output logic ready
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic             settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      settled <= 1'b0;
      ready   <= 1'b0;
    end else begin
      if (gsb) begin
        cnt     <= '0;
        settled <= 1'b0;
      end else if (!settled) begin
        if (cnt == LAST) settled <= 1'b1;
        else             cnt     <= cnt + CNT_W'(1);
      end
      ready <= settled && !gsb && !sleep;
    end
  end

  // R9
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(!gsb && !sleep));
  // R8
  ready_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(settled));
endmodule

// File: rtl/codec_pwr_seq.sv
`timescale 1ns/1ps
module codec_pwr_seq #(
  parameter int ADDR_W     = 5,
  parameter int RAMP_LEN   = 1024,
  parameter int SETTLE_LEN = 2688000,
  localparam int LVL_W = $clog2(RAMP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              dac_standby,
  output logic              adc_standby,
  output logic              mixer_standby,
  output logic [LVL_W-1:0]  out_level,
  output logic              ramp_up_flag,
  output logic              ramp_down_flag,
  output logic              ready
);
  logic stage_sb, gsb, sleep, up_done, down_done;

  cpwr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr),
    .set_up(up_done), .set_down(down_done),
    .rd_data(rd_data),
    .stage_sb(stage_sb),
    .dac_sb(dac_standby), .adc_sb(adc_standby), .mix_sb(mixer_standby),
    .gsb(gsb), .sleep(sleep),
    .flag_up(ramp_up_flag), .flag_down(ramp_down_flag)
  );

  cpwr_ramp #(.RAMP_LEN(RAMP_LEN)) u_ramp (
    .clk(clk), .rst(rst),
    .stage_sb(stage_sb),
    .level(out_level),
    .up_done(up_done), .down_done(down_done)
  );

  cpwr_settle #(.SETTLE_LEN(SETTLE_LEN)) u_settle (
    .clk(clk), .rst(rst),
    .gsb(gsb), .sleep(sleep),
    .ready(ready)
  );

  // R5
  one_done_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({up_done, down_done}));
endmodule

// File: tb/tb_codec_pwr_seq.sv
`timescale 1ns/1ps
module tb_codec_pwr_seq;
  localparam int ADDR_W = 5;
  localparam int RL     = 8;
  localparam int SL     = 20;
  localparam int LW     = $clog2(RL + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_data;
  logic              dac_standby, adc_standby, mixer_standby;
  logic [LW-1:0]     out_level;
  logic              ramp_up_flag, ramp_down_flag, ready;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  codec_pwr_seq #(.ADDR_W(ADDR_W), .RAMP_LEN(RL), .SETTLE_LEN(SL)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .dac_standby(dac_standby), .adc_standby(adc_standby), .mixer_standby(mixer_standby),
    .out_level(out_level), .ramp_up_flag(ramp_up_flag), .ramp_down_flag(ramp_down_flag),
    .ready(ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = 8'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = ADDR_W'(a);
    tick(1);
    d = int'(rd_data);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 level", int'(out_level), 0);
    chk("R1 up flag", int'(ramp_up_flag), 0);
    chk("R1 down flag", int'(ramp_down_flag), 0);
    chk("R1 ready", int'(ready), 0);
    chk("R1 standby outs", int'({dac_standby, adc_standby, mixer_standby}), 7);
    rd(0, v); chk("R1 pwr reg", v, 8'hFF);
    rd(1, v); chk("R1 global reg", v, 8'h03);
    rd(2, v); chk("R6 flags after reset", v, 0);
  endtask

  task automatic t_ramp_up();
    int v;
    wr(0, 8'hBF);
    chk("R2 level at write edge", int'(out_level), 0);
    tick(3);
    chk("R2 level mid ramp", int'(out_level), 3);
    tick(RL - 3);
    chk("R2 level at top", int'(out_level), RL);
    chk("R2 up flag not yet", int'(ramp_up_flag), 0);
    tick(1);
    chk("R2 up flag set", int'(ramp_up_flag), 1);
    rd(2, v); chk("R6 flags live read", v, 8'h08);
    tick(5);
    chk("R4 up flag sticky", int'(ramp_up_flag), 1);
  endtask

  task automatic t_ramp_down();
    wr(2, 8'h00);
    chk("R4 clear by zero", int'(ramp_up_flag), 0);
    wr(0, 8'hFF);
    chk("R3 level at write edge", int'(out_level), RL);
    tick(RL);
    chk("R3 level at zero", int'(out_level), 0);
    chk("R3 down flag not yet", int'(ramp_down_flag), 0);
    tick(1);
    chk("R3 down flag set", int'(ramp_down_flag), 1);
    chk("R3 up flag untouched", int'(ramp_up_flag), 0);
  endtask

  task automatic t_write_one();
    wr(2, 8'h04);
    chk("R4 write one keeps flag", int'(ramp_down_flag), 1);
    wr(2, 8'h08);
    chk("R4 write zero clears flag", int'(ramp_down_flag), 0);
    chk("R4 write one does not set", int'(ramp_up_flag), 0);
  endtask

  task automatic t_reverse();
    wr(0, 8'hBF);
    tick(5);
    chk("R5 level before reversal", int'(out_level), 5);
    wr(0, 8'hFF);
    chk("R5 level at reversal edge", int'(out_level), 6);
    tick(6);
    chk("R5 level back at zero", int'(out_level), 0);
    chk("R5 no up flag", int'(ramp_up_flag), 0);
    tick(1);
    chk("R5 down flag only", int'({ramp_up_flag, ramp_down_flag}), 1);
    wr(2, 8'h00);
  endtask

  task automatic t_standby_bits();
    wr(0, 8'h6F);
    chk("R7 dac", int'(dac_standby), 0);
    chk("R7 mixer", int'(mixer_standby), 1);
    chk("R7 adc", int'(adc_standby), 0);
    tick(2);
    chk("R7 ramp untouched", int'(out_level), 0);
    wr(0, 8'hDF);
    chk("R7 bits swapped", int'({dac_standby, mixer_standby, adc_standby}), 3'b101);
  endtask

  task automatic t_unmapped();
    int v;
    wr(7, 8'h00);
    chk("R10 dac unchanged", int'(dac_standby), 1);
    chk("R10 flags unchanged", int'({ramp_up_flag, ramp_down_flag}), 0);
    tick(2);
    chk("R10 level unchanged", int'(out_level), 0);
    rd(0, v); chk("R10 pwr reg unchanged", v, 8'hDF);
    rd(7, v); chk("R10 unmapped read", v, 0);
  endtask

  task automatic t_settle();
    wr(1, 8'h00);
    tick(SL);
    chk("R8 ready not yet", int'(ready), 0);
    tick(1);
    chk("R8 ready after settle", int'(ready), 1);
    wr(1, 8'h01);
    chk("R9 ready at sleep edge", int'(ready), 1);
    tick(1);
    chk("R9 ready low in sleep", int'(ready), 0);
    wr(1, 8'h00);
    tick(1);
    chk("R9 sleep keeps settle", int'(ready), 1);
    wr(1, 8'h02);
    tick(1);
    chk("R9 ready low in standby", int'(ready), 0);
    wr(1, 8'h00);
    tick(SL);
    chk("R9 settle restarted", int'(ready), 0);
    tick(1);
    chk("R9 ready after restart", int'(ready), 1);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_ramp_up();
    t_ramp_down();
    t_write_one();
    t_reverse();
    t_standby_bits();
    t_unmapped();
    t_settle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule